// File: doc/BRIEF.md
# Ping-pong memory interleaver

This block reorders a continuous sample stream with two equal memory banks that trade places. At any moment one bank is the fill bank: the caller writes samples into it at whatever addresses it chooses, and those addresses set the new order. The other bank is the drain bank. It is read without pause in ascending address order, from address 0 up to the last entry, and then it wraps back to 0.

The caller sends a one-cycle swap request once a block has been loaded. This request may share its cycle with the last write of the block. The exchange is held until the read sweep reaches its next wrap, so each drain pass always begins at address 0. Two pulse outputs lead the data by one cycle. The first marks the start of every sweep. The second marks the start of a sweep that reads from a freshly exchanged bank. Read data is registered and trails the sweep address by one cycle. Memory contents are not cleared by reset.

Top module: `pingpong_interleaver`

## Requirements
- R1: While `rst` is high on a clock edge, `sync_zero` and `sync_bank` are low and the read sweep returns to address 0. The first `sync_zero` pulse after reset is released comes 2^AW cycles after the first clock edge with `rst` low, counting that edge as cycle 1.
- R2: A write changes only the current fill bank. It never disturbs the data that the drain bank is presenting.
- R3: In the cycles after a `sync_zero` pulse, `rd_data` presents drain-bank entries 0, 1, 2 … 2^AW−1, one per cycle. Entry 0 appears in the cycle directly after the pulse.
- R4: `sync_zero` is a single-cycle pulse that repeats exactly every 2^AW cycles. It is always high exactly one cycle before entry 0 appears on `rd_data`.
- R5: A swap request is remembered until the next sweep wrap, and the banks exchange at that wrap. The bank that was just filled is then drained in the sweep that starts with the following `sync_zero`.
- R6: `sync_bank` is high only together with `sync_zero`, and only on the wrap at which the banks exchange.
- R7: A write in the same cycle as a swap request lands in the bank that is being filled at that moment, so it shows up in the drained block that follows the exchange.
- R8: Several swap requests that arrive before one wrap cause a single exchange. The next wrap without a new request gives `sync_zero` with `sync_bank` low.
- R9: A swap request in the last cycle of a sweep, when address 2^AW−1 is being issued (one cycle before `sync_zero`), takes effect at that same wrap.
- R10: With `wr_en` low, `wr_addr` and `wr_data` have no effect on either bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| swap_req | input | 1 | One-cycle request to exchange the banks at the next wrap |
| wr_en | input | 1 | Write strobe for the fill bank |
| wr_addr | input | AW | Fill-bank write address |
| wr_data | input | DW | Fill-bank write data |
| sync_bank | output | 1 | Lead pulse: the next entry 0 comes from a newly exchanged bank |
| sync_zero | output | 1 | Lead pulse: the next `rd_data` is entry 0 |
| rd_data | output | DW | Drain-bank data in ascending address order |

## Verification
Two functions can fall in the same cycle: the last fill write of a block and the swap request. The bench places them together and checks that the word written in that cycle comes out in the drained block (R7). The swap request can also coincide with the sweep wrap itself. The bench counts cycles from a `sync_zero` pulse so that it raises the request while the last address is being issued, and then expects `sync_bank` on the very next pulse rather than one sweep later (R9). A scoreboard queue holds the expected drained words in address order, and every exchange sweep is compared entry by entry against it.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int BANKS = 2;

  // Bank-select update: flips only when an exchange fires.
  function automatic logic next_fill_sel(input logic cur, input logic fire);
    return cur ^ fire;
  endfunction
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ilv_sweep.sv
module ilv_sweep #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          swap_due,
  output logic [AW-1:0] rd_addr,
  output logic          wrap,
  output logic          sync_zero,
  output logic          sync_bank
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  function automatic logic [AW-1:0] advance(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  assign wrap = (rd_addr == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_addr   <= '0;
      sync_zero <= 1'b0;
      sync_bank <= 1'b0;
    end else begin
      rd_addr   <= advance(rd_addr);
      sync_zero <= wrap;
      sync_bank <= wrap && swap_due;
    end
  end
endmodule

// File: rtl/ilv_swap_ctl.sv
module ilv_swap_ctl (
  input  logic clk,
  input  logic rst,
  input  logic swap_req,
  input  logic wrap,
  output logic fill_sel,
  output logic swap_pend,
  output logic swap_due
);
  import ilv_pkg::*;

  logic fire;

  assign swap_due = swap_pend | swap_req;
  assign fire     = wrap & swap_due;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_sel  <= 1'b0;
      swap_pend <= 1'b0;
    end else begin
      fill_sel <= next_fill_sel(fill_sel, fire);
      if (fire)          swap_pend <= 1'b0;
      else if (swap_req) swap_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/pingpong_interleaver.sv
module pingpong_interleaver #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          swap_req,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          sync_bank,
  output logic          sync_zero,
  output logic [DW-1:0] rd_data
);
  import ilv_pkg::*;

  logic [AW-1:0] rd_addr;
  logic          wrap;
  logic          fill_sel;
  logic          swap_pend;
  logic          swap_due;
  logic          drain_q;
  logic [DW-1:0] bank_rd [BANKS];

  ilv_sweep #(.AW(AW)) u_sweep (
    .clk(clk), .rst(rst), .swap_due(swap_due),
    .rd_addr(rd_addr), .wrap(wrap),
    .sync_zero(sync_zero), .sync_bank(sync_bank)
  );

  ilv_swap_ctl u_ctl (
    .clk(clk), .rst(rst), .swap_req(swap_req), .wrap(wrap),
    .fill_sel(fill_sel), .swap_pend(swap_pend), .swap_due(swap_due)
  );

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic we_g;
    assign we_g = wr_en && (fill_sel == 1'(g));
    ilv_bank #(.AW(AW), .DW(DW)) u_bank (
      .clk(clk), .we(we_g), .waddr(wr_addr), .wdata(wr_data),
      .raddr(rd_addr), .rdata(bank_rd[g])
    );
  end

  // Drain selection aligned with the registered read.
  always_ff @(posedge clk) begin
    if (rst) drain_q <= 1'b1;
    else     drain_q <= ~fill_sel;
  end

  assign rd_data = bank_rd[drain_q];
endmodule

// File: rtl/ilv_checker.sv
module ilv_checker #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          swap_req,
  input logic          sync_bank,
  input logic          sync_zero,
  input logic          fill_sel,
  input logic          swap_pend,
  input logic [AW-1:0] rd_addr
);
  p_bank_with_zero_r6: assert property (@(posedge clk) disable iff (rst)
    sync_bank |-> sync_zero);

  p_zero_marks_addr0_r4: assert property (@(posedge clk) disable iff (rst)
    sync_zero |-> (rd_addr == '0));

  p_sweep_steps_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rd_addr == AW'($past(rd_addr) + 1'b1)));

  p_sel_moves_on_exchange_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(fill_sel) |-> sync_bank);

  p_request_held_r5: assert property (@(posedge clk) disable iff (rst)
    swap_req |=> (swap_pend || sync_bank));

  p_single_exchange_r8: assert property (@(posedge clk) disable iff (rst)
    sync_bank |-> !swap_pend);
endmodule

bind pingpong_interleaver ilv_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .swap_req(swap_req), .sync_bank(sync_bank),
  .sync_zero(sync_zero), .fill_sel(fill_sel), .swap_pend(swap_pend),
  .rd_addr(rd_addr)
);

// File: tb/pingpong_interleaver_tb_top.sv
module pingpong_interleaver_tb_top;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int N  = 1 << AW;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic swap_req = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic sync_bank, sync_zero;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int fails = 0;
  int bank_events = 0;
  int zero_events = 0;
  bit swap_expected = 1'b0;
  bit released = 1'b0;
  logic [DW-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pingpong_interleaver #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .swap_req(swap_req), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sync_bank(sync_bank),
    .sync_zero(sync_zero), .rd_data(rd_data)
  );

  function automatic logic [DW-1:0] pat(int a, int ph);
    return DW'(ph * 4099 + a * 77 + 'h5a00);
  endfunction

  function automatic int perm(int i, int ph);
    return (i * 37 + ph * 5) % N;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // Monitor: sync timing and scoreboard comparison.
  int armed = 0;
  int gap = 0;
  bit first_zero = 1'b1;
  always @(negedge clk) begin
    if (rst) begin
      check(sync_zero == 1'b0 && sync_bank == 1'b0, "R1 sync low in reset",
            {sync_zero, sync_bank}, 0);
    end else if (released) begin
      gap++;
      if (armed > 0) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 scoreboard empty", rd_data, 0);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(rd_data === e, "R3/R7/R10 drained word", rd_data, e);
        end
        armed--;
      end
      if (!sync_zero && sync_bank)
        check(1'b0, "R6 bank pulse without zero pulse", 1, 0);
      if (sync_zero) begin
        check(gap == N, first_zero ? "R1 first zero pulse" : "R4 zero period", gap, N);
        first_zero = 1'b0;
        gap = 0;
        zero_events++;
        check(sync_bank == swap_expected, "R6/R8/R9 bank pulse", sync_bank, swap_expected);
        if (sync_bank) begin
          bank_events++;
          swap_expected = 1'b0;
          armed = N;
        end
      end
    end
  end

  task automatic idle_inputs();
    wr_en = 1'b0; swap_req = 1'b0;
  endtask

  // Driver: fill one block in permuted order, then push expected words.
  task automatic fill_block(int ph, bit swap_on_last, bit with_skip);
    for (int i = 0; i < N; i++) begin
      @(negedge clk); #1;
      wr_en = 1'b1;
      wr_addr = AW'(perm(i, ph));
      wr_data = pat(perm(i, ph), ph);
      swap_req = swap_on_last && (i == N - 1);
      if (swap_req) swap_expected = 1'b1;
      if (with_skip && i == 10) begin
        // R10: disabled write of garbage to an already written address
        @(negedge clk); #1;
        wr_en = 1'b0;
        wr_addr = AW'(perm(3, ph));
        wr_data = ~pat(perm(3, ph), ph);
      end
    end
    @(negedge clk); #1;
    idle_inputs();
    for (int a = 0; a < N; a++) exp_q.push_back(pat(a, ph));
  endtask

  task automatic pulse_swap();
    #1; swap_req = 1'b1; swap_expected = 1'b1;
    @(negedge clk); #1; swap_req = 1'b0;
  endtask

  task automatic wait_zero();
    int t;
    t = zero_events + 1;
    wait (zero_events >= t);
  endtask

  initial begin
    int tgt;
    repeat (4) @(negedge clk);
    #1; rst = 1'b0; released = 1'b1;

    // Phase 1 (R7, R2): swap request on the last write.
    tgt = bank_events + 1;
    fill_block(1, 1'b1, 1'b0);
    wait (bank_events >= tgt);

    // Phase 2 (R10, R9): disabled write, swap on the last sweep cycle.
    tgt = bank_events + 1;
    fill_block(2, 1'b0, 1'b1);
    wait_zero();
    repeat (N - 1) @(negedge clk);
    pulse_swap();
    wait (bank_events >= tgt);

    // Phase 3 (R8): two requests within one sweep, one exchange.
    tgt = bank_events + 1;
    fill_block(3, 1'b0, 1'b0);
    wait_zero();
    repeat (3) @(negedge clk);
    pulse_swap();
    repeat (5) @(negedge clk);
    pulse_swap();
    wait (bank_events >= tgt);
    wait_zero();

    // Phase 4 (R5): request issued well after loading.
    tgt = bank_events + 1;
    fill_block(4, 1'b0, 1'b0);
    repeat (17) @(negedge clk);
    pulse_swap();
    wait (bank_events >= tgt);
    repeat (N + 6) @(negedge clk);

    check(exp_q.size() == 0, "R3 all expected words drained", exp_q.size(), 0);
    check(bank_events == 4, "R5 exchange count", bank_events, 4);
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end
endmodule